// File: doc/BRIEF.md
# Supervisory Reset Generator with Watchdog

This block produces the system reset for a processor from three sources. The first is a supply-low flag that an external comparator delivers synchronously. The second is an active-low manual reset line. The third is a watchdog that the processor must service by toggling a kick line.

While any trigger is present, reset stays asserted. Once the last trigger goes away, reset is held for one further reset timeout. If the kick line shows no edge for a full watchdog timeout, the watchdog starts a reset pulse of one reset timeout. The watchdog cannot be switched off. It is held cleared for the whole time reset is asserted.

Both timeouts are parameters counted in time-base ticks. A tick-enable input lets the counters advance on a prescaled base, such as one tick per millisecond in silicon. Tying tick-enable high gives short cycle-scaled runs in simulation.

Top module: `supv_reset_top`

## Requirements
- R1: While `supplyLow` is high at a clock edge, `resetN` is 0 after that edge and the reset timeout restarts from zero. A new assertion during a running timeout therefore restarts the full timeout.
- R2: After the last edge at which a trigger is seen, `resetN` stays 0 for exactly `RST_CYCLES` further ticks. It goes to 1 after the edge that carries the last of those ticks.
- R3: `manRstN` passes through a two-flop synchronizer. If it is driven low before clock edge e, `resetN` is 0 after edge e+2 and stays 0 while the input stays low.
- R4: After `manRstN` returns high, reset is held for one full reset timeout (R2), counted from the synchronized release.
- R5: `wdKick` passes through a two-flop synchronizer. Any change of the synchronized value, rising or falling, clears the watchdog count.
- R6: While reset is asserted, the watchdog count is held at zero. It starts counting ticks in the first cycle after reset deasserts.
- R7: When `WD_CYCLES` ticks pass with reset deasserted and no kick edge, `resetN` goes to 0 after the edge that carries the last of those ticks. A normal reset timeout (R2) follows.
- R8: With `wdKick` stuck at either level and `tickEn` high, `resetN` falls once every `WD_CYCLES + RST_CYCLES` cycles. It stays high for `WD_CYCLES` cycles and low for `RST_CYCLES` cycles.
- R9: `resetHi` is always the logical inverse of `resetN`.
- R10: While `rstN` is low, `resetN` is 0. After `rstN` is released, reset runs one full reset timeout starting from zero.
- R11: In a cycle where `tickEn` is low, neither the reset timeout count nor the watchdog count advances. Triggers and kick edges still act in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Block power-on reset, active low, asynchronous |
| supplyLow | input | 1 | Synchronous flag: supply is below the reset threshold |
| manRstN | input | 1 | Manual reset request, active low, asynchronous |
| wdKick | input | 1 | Watchdog service line; either edge counts, asynchronous |
| tickEn | input | 1 | Time-base tick; the counters advance only in cycles where it is high |
| resetN | output | 1 | Reset to the system, active low |
| resetHi | output | 1 | Reset to the system, active high, inverse of resetN |

## Verification
A supply-low flag shows on `resetN` after the first clock edge that samples it. The manual reset line and the kick line pass through two synchronizer flops, so their effect lands two edges later. The timeouts end on the edge that carries the last counted tick. The bench models each of these latencies as it stands, using queues for the synchronizer depth and integer counts for the timeouts. It updates the model at each rising edge and compares it with the outputs at the following falling edge, once the outputs have settled. Direct checks at fixed falling edges confirm the first-cycle responses. Measured distances between transitions of `resetN` confirm the pulse and period lengths.

// File: rtl/supv_pkg.sv
`timescale 1ns/1ps
package supv_pkg;
  // Strobes passed from the control side to the counter datapath.
  typedef struct packed {
    logic hold;   // some trigger currently forces reset
    logic kick;   // synchronized kick line changed this cycle
    logic tick;   // time base advances this cycle
  } supvStrobe_t;
endpackage

// File: rtl/supv_ctrl.sv
`timescale 1ns/1ps
module supv_ctrl
  import supv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyLow,
  input  logic        manRstN,
  input  logic        wdKick,
  input  logic        tickEn,
  output supvStrobe_t strb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] mrSync;
  logic [LAST:0] kickSync;
  logic          kickPrev;

  // Synchronizer chains. Idle values: manual reset released, kick low.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mrSync   <= '1;
      kickSync <= '0;
      kickPrev <= 1'b0;
    end else begin
      mrSync   <= {mrSync[LAST-1:0], manRstN};
      kickSync <= {kickSync[LAST-1:0], wdKick};
      kickPrev <= kickSync[LAST];
    end
  end

  always_comb begin
    strb.hold = supplyLow | ~mrSync[LAST];
    strb.kick = kickSync[LAST] ^ kickPrev;
    strb.tick = tickEn;
  end

  // R5: a kick strobe marks a change of the synchronized kick value.
  kick_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.kick |=> (kickPrev != $past(kickPrev)));
endmodule

// File: rtl/supv_timers.sv
`timescale 1ns/1ps
module supv_timers
  import supv_pkg::*;
#(
  parameter int RST_CYCLES = 12,
  parameter int WD_CYCLES  = 30
) (
  input  logic        clk,
  input  logic        rstN,
  input  supvStrobe_t strb,
  output logic        rstActive
);
  localparam int RW = $clog2(RST_CYCLES + 1);
  localparam int WW = $clog2(WD_CYCLES + 1);
  localparam logic [RW-1:0] RST_LAST = RW'(RST_CYCLES - 1);
  localparam logic [WW-1:0] WD_LAST  = WW'(WD_CYCLES - 1);

  logic [RW-1:0] rstCnt;
  logic [WW-1:0] wdCnt;
  logic          wdFire;
  logic          rstDone;

  assign rstDone = rstActive && strb.tick && (rstCnt == RST_LAST);
  assign wdFire  = !rstActive && !strb.kick && strb.tick && (wdCnt == WD_LAST);

  // Reset timeout: a trigger or a watchdog expiry reloads it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstActive <= 1'b1;
      rstCnt    <= '0;
    end else if (strb.hold || wdFire) begin
      rstActive <= 1'b1;
      rstCnt    <= '0;
    end else if (rstDone) begin
      rstActive <= 1'b0;
      rstCnt    <= '0;
    end else if (rstActive && strb.tick) begin
      rstCnt    <= rstCnt + 1'b1;
    end
  end

  // Watchdog count: cleared while in reset, on a kick, or when it fires.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdCnt <= '0;
    end else if (rstActive || strb.kick || wdFire) begin
      wdCnt <= '0;
    end else if (strb.tick) begin
      wdCnt <= wdCnt + 1'b1;
    end
  end

  // R1
  supply_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.hold |=> (rstActive && rstCnt == '0));

  // R2
  timeout_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstActive) |-> ($past(rstCnt) == RST_LAST && $past(strb.tick)));

  // R6
  wd_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstActive |=> (wdCnt == '0));

  // R7
  wd_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rstActive) && !$past(strb.hold)) |-> ($past(wdCnt) == WD_LAST));

  // R11
  tick_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.hold) |=> ($stable(rstCnt) && $stable(rstActive)));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstCnt <= RST_LAST);
endmodule

// File: rtl/supv_reset_top.sv
`timescale 1ns/1ps
module supv_reset_top
  import supv_pkg::*;
#(
  parameter int RST_CYCLES  = 12,
  parameter int WD_CYCLES   = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyLow,
  input  logic manRstN,
  input  logic wdKick,
  input  logic tickEn,
  output logic resetN,
  output logic resetHi
);
  supvStrobe_t strb;
  logic        rstActive;

  supv_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .supplyLow(supplyLow), .manRstN(manRstN),
    .wdKick(wdKick), .tickEn(tickEn), .strb(strb)
  );

  supv_timers #(.RST_CYCLES(RST_CYCLES), .WD_CYCLES(WD_CYCLES)) timers_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rstActive(rstActive)
  );

  assign resetN  = ~rstActive;
  assign resetHi = rstActive;
endmodule

// File: tb/supv_reset_top_tb_top.sv
`timescale 1ns/1ps
module supv_reset_top_tb_top;
  localparam int RST = 12;
  localparam int WD  = 30;

  logic clk = 1'b0;
  logic rstN, supplyLow, manRstN, wdKick, tickEn;
  logic resetN, resetHi;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  string phase = "R10";
  bit finished = 1'b0;

  always #2 clk = ~clk;

  supv_reset_top #(.RST_CYCLES(RST), .WD_CYCLES(WD)) dut_i (
    .clk(clk), .rstN(rstN), .supplyLow(supplyLow), .manRstN(manRstN),
    .wdKick(wdKick), .tickEn(tickEn), .resetN(resetN), .resetHi(resetHi)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // Behavioural reference model, updated at each rising edge.
  bit mrQ[$];
  bit kQ[$];
  bit mAsserted;
  int mRemain, mIdle;
  bit modelValid = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      mrQ = '{1'b1, 1'b1};
      kQ  = '{1'b0, 1'b0, 1'b0};
      mAsserted = 1'b1; mRemain = RST; mIdle = 0;
      modelValid = 1'b0;
    end else begin
      bit mrSeen, kickSeen, holdNow;
      mrSeen   = mrQ[0];
      kickSeen = kQ[0] ^ kQ[1];
      void'(mrQ.pop_front()); mrQ.push_back(manRstN);
      void'(kQ.pop_front());  kQ.push_back(wdKick);
      holdNow = supplyLow || !mrSeen;
      if (holdNow) begin
        mAsserted = 1'b1; mRemain = RST; mIdle = 0;
      end else if (mAsserted) begin
        if (tickEn) begin
          mRemain--;
          if (mRemain == 0) begin mAsserted = 1'b0; mIdle = 0; end
        end
      end else if (kickSeen) begin
        mIdle = 0;
      end else if (tickEn) begin
        mIdle++;
        if (mIdle == WD) begin mAsserted = 1'b1; mRemain = RST; mIdle = 0; end
      end
      modelValid = 1'b1;
    end
  end

  // Compare away from the active edge, every cycle.
  always @(negedge clk) begin
    cyc++;
    if (rstN && modelValid && !finished) begin
      check(resetN == !mAsserted, phase, resetN, !mAsserted);
      check(resetHi == !resetN, "R9", resetHi, !resetN);
    end
  end

  task automatic run(input int n, input int kickEvery);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (kickEvery > 0 && (i % kickEvery) == 0) wdKick = ~wdKick;
    end
  endtask

  initial begin
    rstN = 1'b0; supplyLow = 1'b0; manRstN = 1'b1; wdKick = 1'b0; tickEn = 1'b1;
    repeat (5) @(negedge clk);
    check(resetN == 1'b0, "R10", resetN, 0);
    check(resetHi == 1'b1, "R9", resetHi, 1);
    rstN = 1'b1;

    // R10 / R2: timeout after power-on, then served watchdog stays quiet.
    phase = "R10";
    run(RST + 2, 4);
    phase = "R5";
    run(60, 4);
    check(resetN == 1'b1, "R5", resetN, 1);

    // R1: supply low asserts after one edge; re-assertion restarts timeout.
    phase = "R1";
    @(negedge clk); supplyLow = 1'b1;
    @(negedge clk);
    check(resetN == 1'b0, "R1", resetN, 0);
    run(6, 3);
    supplyLow = 1'b0;
    run(5, 3);
    supplyLow = 1'b1;
    run(2, 3);
    supplyLow = 1'b0;
    phase = "R2";
    run(40, 3);
    check(resetN == 1'b1, "R2", resetN, 1);

    // R3 / R4: manual reset through the synchronizer.
    phase = "R3";
    @(negedge clk); manRstN = 1'b0;
    @(negedge clk); @(negedge clk);
    check(resetN == 1'b1, "R3", resetN, 1);
    @(negedge clk);
    check(resetN == 1'b0, "R3", resetN, 0);
    run(20, 5);
    manRstN = 1'b1;
    phase = "R4";
    run(40, 5);

    // R5: kicks on every cycle and every other cycle, both edges count.
    phase = "R5";
    run(80, 1);
    run(80, 2);
    check(resetN == 1'b1, "R5", resetN, 1);

    // R6 / R7 / R8: stuck kick line, measure the pulse train.
    phase = "R7";
    begin
      int evT[$];
      bit evL[$];
      bit prev;
      prev = resetN;
      for (int i = 0; i < 4 * (WD + RST); i++) begin
        @(negedge clk);
        if (resetN != prev) begin evT.push_back(i); evL.push_back(resetN); end
        prev = resetN;
      end
      check(evT.size() >= 5, "R8", evT.size(), 5);
      for (int j = 1; j < evT.size(); j++) begin
        if (evL[j]) check(evT[j] - evT[j-1] == RST, "R7", evT[j] - evT[j-1], RST);
        else        check(evT[j] - evT[j-1] == WD,  "R6", evT[j] - evT[j-1], WD);
        if (j >= 2) check(evT[j] - evT[j-2] == WD + RST, "R8",
                          evT[j] - evT[j-2], WD + RST);
      end
    end
    wdKick = 1'b1;
    phase = "R8";
    run(2 * (WD + RST), 0);

    // R11: frozen time base keeps reset asserted indefinitely.
    phase = "R11";
    @(negedge clk); tickEn = 1'b0; supplyLow = 1'b1;
    @(negedge clk); supplyLow = 1'b0;
    run(50, 4);
    check(resetN == 1'b0, "R11", resetN, 0);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      tickEn = (i % 3) == 0;
      if (i < 200 && (i % 7) == 0) wdKick = ~wdKick;
      if (i == 250) manRstN = 1'b0;
      if (i == 256) manRstN = 1'b1;
    end
    tickEn = 1'b1;
    run(60, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog cycle=%0d actual=%0d expected=%0d", cyc, 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule